// File: doc/BRIEF.md
# Clocked Serial Host Slave Port

This block lets a host microcontroller exchange bytes with a radio core over a four-wire clocked serial link in which the block is always the slave. The host clock, the active-low chip select and the data input are brought into the system clock domain through synchronizer chains. All shifting happens on rising host clock edges seen while the chip select is low. A mode input picks whether each byte travels most significant bit first or least significant bit first, for both directions.

Every transaction opens with a command byte. While the host shifts in its request bits, the block shifts out the core's status bits, and only positions where both are 1 start an operation. A length byte follows, and then data bytes. Configuration accesses always move one 16-bit word as two bytes, low byte first. MAC/PHY accesses move as many bytes as the length byte names. On the core side there are single-cycle write strobes carrying data, and read-acknowledge strobes for a show-ahead byte source and for a 16-bit configuration word. An active-low interrupt output signals that the core has data waiting for the host.

Top module: `hsi_slave`

## Requirements
- R1: During the command byte the block shifts out the byte {4'b0000, stat_i[3:0]}, with stat_i taken in the cycle the chip select falling edge is detected. Status bit 3 means configuration write allowed, bit 2 configuration data ready, bit 1 MAC/PHY write allowed and bit 0 MAC/PHY data ready.
- R2: With msb_first_i = 1, bit 7 of each byte is sent and received first, in both directions.
- R3: With msb_first_i = 0, bit 0 of each byte is sent and received first, in both directions.
- R4: An operation starts only where a request bit from the host and the matching status bit are both 1. With no such position, the transaction moves no data: there are no core strobes and the block sends zeros.
- R5: When several positions match, one operation runs, chosen in this priority: configuration write (bit 3), configuration read (bit 2), MAC/PHY write (bit 1), MAC/PHY read (bit 0). At most one core strobe is active in any cycle.
- R6: A MAC/PHY write with length byte N pulses mac_wr_o once for each of the first N data bytes, with the received byte on mac_wdata_o. Later bytes are ignored.
- R7: A MAC/PHY read with length byte N sends N bytes taken from mac_rdata_i, pulsing mac_rd_o in each cycle a byte is taken. Later bytes are sent as zero.
- R8: A configuration write ignores the length value, takes exactly two data bytes (bits 7:0 first, then bits 15:8) and pulses cfg_wr_o once with the 16-bit word on cfg_wdata_o.
- R9: A configuration read samples cfg_rdata_i once, with a single cfg_rd_o pulse at the end of the length byte, and sends bits 7:0 and then bits 15:8.
- R10: A MAC/PHY access whose length byte is 0 moves no data.
- R11: irq_n_o goes low one cycle after stat_i bit 2 or bit 0 is 1, and returns high one cycle after both are 0.
- R12: Raising the chip select aborts the transaction: sdo_o is held at 0 and the bit and byte position return to the start, so the next transaction begins with a command byte.
- R13: After reset sdo_o is 0, irq_n_o is 1 and no core strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the host clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Host serial clock |
| scs_n_i | input | 1 | Host chip select, active low |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| irq_n_o | output | 1 | Active-low interrupt: core has data to read |
| msb_first_i | input | 1 | Bit order: 1 = bit 7 first, 0 = bit 0 first |
| stat_i | input | 4 | Core status / enable bits |
| cfg_rdata_i | input | 16 | Configuration word to send to the host |
| cfg_rd_o | output | 1 | Strobe: cfg_rdata_i taken |
| cfg_wr_o | output | 1 | Strobe: configuration word written |
| cfg_wdata_o | output | 16 | Configuration word from the host |
| mac_rdata_i | input | 8 | Head byte of the MAC/PHY read source |
| mac_rd_o | output | 1 | Strobe: mac_rdata_i taken |
| mac_wr_o | output | 1 | Strobe: MAC/PHY byte written |
| mac_wdata_o | output | 8 | MAC/PHY byte from the host |

## Verification
On every cycle the assertions check that each core strobe appears only under the operation it belongs to, that no two strobes coincide, that an idle chip select keeps the output and all strobes quiet, and that a pending read request pulls the interrupt low. Only the bench scenarios can show the serial byte contents in both bit orders, the status byte of the command phase, the length-limited byte counts, the low-then-high order of configuration words, and the restart after an aborted transaction.

// File: rtl/hsi_pkg.sv
package hsi_pkg;

    localparam int BYTE_W    = 8;
    localparam int STAT_W    = 4;
    localparam int CFG_BYTES = 2;
    localparam int CFG_W     = CFG_BYTES * BYTE_W;
    localparam int CNT_W     = $clog2(BYTE_W);

    // positions of request / status bits in the command byte
    localparam int REQ_CFG_WR = 3;
    localparam int REQ_CFG_RD = 2;
    localparam int REQ_MAC_WR = 1;
    localparam int REQ_MAC_RD = 0;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CFG_WR,
        OP_CFG_RD,
        OP_MAC_WR,
        OP_MAC_RD
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_LEN,
        PH_DATA,
        PH_SKIP
    } phase_e;

    // synchronized view of the serial pins
    typedef struct packed {
        logic active;
        logic start;
        logic rise;
        logic sdi;
    } ser_ev_t;

    function automatic logic [BYTE_W-1:0] bit_rev(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

    function automatic op_e pick_op(input logic [STAT_W-1:0] m);
        if (m[REQ_CFG_WR])      return OP_CFG_WR;
        else if (m[REQ_CFG_RD]) return OP_CFG_RD;
        else if (m[REQ_MAC_WR]) return OP_MAC_WR;
        else if (m[REQ_MAC_RD]) return OP_MAC_RD;
        return OP_NONE;
    endfunction

    function automatic logic is_cfg(input op_e op);
        return (op == OP_CFG_WR) || (op == OP_CFG_RD);
    endfunction

endpackage

// File: rtl/hsi_sync.sv
module hsi_sync
    import hsi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk_i,
    input  logic    scs_n_i,
    input  logic    sdi_i,
    output ser_ev_t ev
);

    // index STAGES-1 is the synchronized value, index STAGES one cycle older
    logic [STAGES:0] sclk_sh;
    logic [STAGES:0] cs_sh;
    logic [STAGES:0] sdi_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sh <= '0;
            cs_sh   <= '1;
            sdi_sh  <= '0;
        end else begin
            sclk_sh <= {sclk_sh[STAGES-1:0], sclk_i};
            cs_sh   <= {cs_sh[STAGES-1:0], scs_n_i};
            sdi_sh  <= {sdi_sh[STAGES-1:0], sdi_i};
        end
    end

    always_comb begin
        ev.active = ~cs_sh[STAGES-1];
        ev.start  = ~cs_sh[STAGES-1] & cs_sh[STAGES];
        ev.rise   = sclk_sh[STAGES-1] & ~sclk_sh[STAGES];
        ev.sdi    = sdi_sh[STAGES-1];
    end

endmodule

// File: rtl/hsi_shifter.sv
module hsi_shifter
    import hsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ser_ev_t           ev,
    input  logic              msb_first_i,
    input  logic [BYTE_W-1:0] stat_byte,
    input  logic [BYTE_W-1:0] next_tx,
    output logic              sdo_o,
    output logic              byte_end,
    output logic [BYTE_W-1:0] rx_byte
);

    logic [BYTE_W-1:0] tx_w;      // transmit byte held in wire order
    logic [BYTE_W-2:0] rx_w;      // received bits in wire order
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_full_w;
    logic              shift;

    function automatic logic [BYTE_W-1:0] to_wire(input logic [BYTE_W-1:0] b,
                                                  input logic msb);
        return msb ? b : bit_rev(b);
    endfunction

    always_comb begin
        shift     = ev.active & ev.rise & ~ev.start;
        byte_end  = shift & (bit_cnt == CNT_W'(BYTE_W - 1));
        rx_full_w = {rx_w, ev.sdi};
        rx_byte   = to_wire(rx_full_w, msb_first_i);
        sdo_o     = ev.active & tx_w[BYTE_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst || !ev.active) begin
            tx_w    <= '0;
            rx_w    <= '0;
            bit_cnt <= '0;
        end else if (ev.start) begin
            tx_w    <= to_wire(stat_byte, msb_first_i);
            rx_w    <= '0;
            bit_cnt <= '0;
        end else if (shift) begin
            rx_w    <= rx_full_w[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            tx_w    <= byte_end ? to_wire(next_tx, msb_first_i)
                                : {tx_w[BYTE_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/hsi_ctrl.sv
module hsi_ctrl
    import hsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ser_ev_t           ev,
    input  logic              byte_end,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [CFG_W-1:0]  cfg_rdata_i,
    input  logic [BYTE_W-1:0] mac_rdata_i,
    output logic [BYTE_W-1:0] stat_byte,
    output logic [BYTE_W-1:0] next_tx,
    output logic              cfg_rd_o,
    output logic              cfg_wr_o,
    output logic [CFG_W-1:0]  cfg_wdata_o,
    output logic              mac_rd_o,
    output logic              mac_wr_o,
    output logic [BYTE_W-1:0] mac_wdata_o,
    output op_e               cur_op
);

    phase_e            phase;
    op_e               op;
    logic [STAT_W-1:0] stat_q;
    logic [BYTE_W-1:0] remain;
    logic [BYTE_W-1:0] cfg_lo;
    logic [BYTE_W-1:0] cfg_hi;
    logic [BYTE_W-1:0] len_rem;
    op_e               sel;

    assign cur_op    = op;
    assign stat_byte = {{(BYTE_W-STAT_W){1'b0}}, stat_i};

    always_comb begin
        sel      = pick_op(rx_byte[STAT_W-1:0] & stat_q);
        len_rem  = is_cfg(op) ? BYTE_W'(CFG_BYTES) : rx_byte;
        next_tx  = '0;
        cfg_rd_o = 1'b0;
        mac_rd_o = 1'b0;
        if (byte_end && ev.active) begin
            unique case (phase)
                PH_LEN: begin
                    if (len_rem != '0) begin
                        if (op == OP_CFG_RD) begin
                            next_tx  = cfg_rdata_i[BYTE_W-1:0];
                            cfg_rd_o = 1'b1;
                        end else if (op == OP_MAC_RD) begin
                            next_tx  = mac_rdata_i;
                            mac_rd_o = 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (remain > BYTE_W'(1)) begin
                        if (op == OP_CFG_RD) begin
                            next_tx = cfg_hi;
                        end else if (op == OP_MAC_RD) begin
                            next_tx  = mac_rdata_i;
                            mac_rd_o = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // sequencing state, cleared whenever the chip select is idle
    always_ff @(posedge clk) begin
        if (rst || !ev.active) begin
            phase    <= PH_IDLE;
            op       <= OP_NONE;
            stat_q   <= '0;
            remain   <= '0;
            cfg_wr_o <= 1'b0;
            mac_wr_o <= 1'b0;
        end else begin
            cfg_wr_o <= 1'b0;
            mac_wr_o <= 1'b0;
            if (ev.start) begin
                phase  <= PH_CMD;
                op     <= OP_NONE;
                stat_q <= stat_i;
            end else if (byte_end) begin
                unique case (phase)
                    PH_CMD: begin
                        op    <= sel;
                        phase <= (sel == OP_NONE) ? PH_SKIP : PH_LEN;
                    end
                    PH_LEN: begin
                        remain <= len_rem;
                        phase  <= (len_rem == '0) ? PH_SKIP : PH_DATA;
                    end
                    PH_DATA: begin
                        remain <= remain - 1'b1;
                        if (remain == BYTE_W'(1)) phase <= PH_SKIP;
                        if (op == OP_MAC_WR) mac_wr_o <= 1'b1;
                        if (op == OP_CFG_WR && remain == BYTE_W'(1)) cfg_wr_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // data holding registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_lo      <= '0;
            cfg_hi      <= '0;
            cfg_wdata_o <= '0;
            mac_wdata_o <= '0;
        end else begin
            if (cfg_rd_o && phase == PH_LEN) cfg_hi <= cfg_rdata_i[CFG_W-1:BYTE_W];
            if (ev.active && byte_end && phase == PH_DATA) begin
                if (op == OP_MAC_WR) mac_wdata_o <= rx_byte;
                if (op == OP_CFG_WR) begin
                    if (remain == BYTE_W'(CFG_BYTES)) cfg_lo <= rx_byte;
                    else cfg_wdata_o <= {rx_byte, cfg_lo};
                end
            end
        end
    end

endmodule

// File: rtl/hsi_slave.sv
module hsi_slave
    import hsi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk_i,
    input  logic        scs_n_i,
    input  logic        sdi_i,
    output logic        sdo_o,
    output logic        irq_n_o,
    input  logic        msb_first_i,
    input  logic [3:0]  stat_i,
    input  logic [15:0] cfg_rdata_i,
    output logic        cfg_rd_o,
    output logic        cfg_wr_o,
    output logic [15:0] cfg_wdata_o,
    input  logic [7:0]  mac_rdata_i,
    output logic        mac_rd_o,
    output logic        mac_wr_o,
    output logic [7:0]  mac_wdata_o
);

    ser_ev_t           ev;
    logic              byte_end;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] stat_byte;
    logic [BYTE_W-1:0] next_tx;
    logic              ser_active;
    op_e               cur_op;

    assign ser_active = ev.active;

    hsi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sclk_i  (sclk_i),
        .scs_n_i (scs_n_i),
        .sdi_i   (sdi_i),
        .ev      (ev)
    );

    hsi_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .msb_first_i (msb_first_i),
        .stat_byte   (stat_byte),
        .next_tx     (next_tx),
        .sdo_o       (sdo_o),
        .byte_end    (byte_end),
        .rx_byte     (rx_byte)
    );

    hsi_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .byte_end    (byte_end),
        .rx_byte     (rx_byte),
        .stat_i      (stat_i),
        .cfg_rdata_i (cfg_rdata_i),
        .mac_rdata_i (mac_rdata_i),
        .stat_byte   (stat_byte),
        .next_tx     (next_tx),
        .cfg_rd_o    (cfg_rd_o),
        .cfg_wr_o    (cfg_wr_o),
        .cfg_wdata_o (cfg_wdata_o),
        .mac_rd_o    (mac_rd_o),
        .mac_wr_o    (mac_wr_o),
        .mac_wdata_o (mac_wdata_o),
        .cur_op      (cur_op)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_n_o <= 1'b1;
        else     irq_n_o <= ~(stat_i[REQ_CFG_RD] | stat_i[REQ_MAC_RD]);
    end

endmodule

// File: rtl/hsi_slave_chk.sv
module hsi_slave_chk
    import hsi_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ser_active,
    input logic       sdo_o,
    input logic       irq_n_o,
    input logic [3:0] stat_i,
    input op_e        cur_op,
    input logic       cfg_rd_o,
    input logic       cfg_wr_o,
    input logic       mac_rd_o,
    input logic       mac_wr_o
);

    // R6
    mac_wr_op_chk: assert property (@(posedge clk) disable iff (rst)
        mac_wr_o |-> cur_op == OP_MAC_WR);

    // R7
    mac_rd_op_chk: assert property (@(posedge clk) disable iff (rst)
        mac_rd_o |-> cur_op == OP_MAC_RD);

    // R8
    cfg_wr_op_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_o |-> cur_op == OP_CFG_WR);

    // R9
    cfg_rd_op_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_o |-> cur_op == OP_CFG_RD);

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_rd_o, cfg_wr_o, mac_rd_o, mac_wr_o}));

    // R12
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !ser_active |-> (!sdo_o && !mac_rd_o && !cfg_rd_o));

    // R12
    idle_wr_chk: assert property (@(posedge clk) disable iff (rst)
        !ser_active |=> (!mac_wr_o && !cfg_wr_o));

    // R11
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_i[REQ_CFG_RD] || stat_i[REQ_MAC_RD]) |=> !irq_n_o);

endmodule

bind hsi_slave hsi_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_active (ser_active),
    .sdo_o      (sdo_o),
    .irq_n_o    (irq_n_o),
    .stat_i     (stat_i),
    .cur_op     (cur_op),
    .cfg_rd_o   (cfg_rd_o),
    .cfg_wr_o   (cfg_wr_o),
    .mac_rd_o   (mac_rd_o),
    .mac_wr_o   (mac_wr_o)
);

// File: tb/hsi_slave_test.sv
module hsi_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int SCLK_HALF  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        scs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo_o;
    logic        irq_n_o;
    logic        msb_first = 1'b1;
    logic [3:0]  stat = 4'b0000;
    logic [15:0] cfg_rdata = 16'h0000;
    logic        cfg_rd_o, cfg_wr_o, mac_rd_o, mac_wr_o;
    logic [15:0] cfg_wdata_o;
    logic [7:0]  mac_rdata;
    logic [7:0]  mac_wdata_o;

    int checks = 0;
    int errors = 0;

    // core-side observation
    int          wr_cnt = 0, rd_cnt = 0, cfg_wr_cnt = 0, cfg_rd_cnt = 0;
    logic [7:0]  wr_log [16];
    logic [15:0] cfg_last = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsi_slave uut (
        .clk         (clk),
        .rst         (rst),
        .sclk_i      (sclk),
        .scs_n_i     (scs_n),
        .sdi_i       (sdi),
        .sdo_o       (sdo_o),
        .irq_n_o     (irq_n_o),
        .msb_first_i (msb_first),
        .stat_i      (stat),
        .cfg_rdata_i (cfg_rdata),
        .cfg_rd_o    (cfg_rd_o),
        .cfg_wr_o    (cfg_wr_o),
        .cfg_wdata_o (cfg_wdata_o),
        .mac_rdata_i (mac_rdata),
        .mac_rd_o    (mac_rd_o),
        .mac_wr_o    (mac_wr_o),
        .mac_wdata_o (mac_wdata_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            mac_rdata <= 8'h50;
        end else begin
            if (mac_rd_o) begin
                mac_rdata <= mac_rdata + 8'h01;
                rd_cnt    <= rd_cnt + 1;
            end
            if (mac_wr_o) begin
                wr_log[wr_cnt % 16] <= mac_wdata_o;
                wr_cnt <= wr_cnt + 1;
            end
            if (cfg_wr_o) begin
                cfg_last   <= cfg_wdata_o;
                cfg_wr_cnt <= cfg_wr_cnt + 1;
            end
            if (cfg_rd_o) cfg_rd_cnt <= cfg_rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // host shifts n bits of tx and collects what the slave sends
    task automatic host_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            int idx;
            idx = msb_first ? 7 - i : i;
            @(negedge clk);
            sclk = 1'b0;
            sdi  = tx[idx];
            repeat (SCLK_HALF - 1) @(negedge clk);
            rx[idx] = sdo_o;
            @(negedge clk);
            sclk = 1'b1;
            repeat (SCLK_HALF - 1) @(negedge clk);
        end
    endtask

    task automatic host_byte(input logic [7:0] tx, output logic [7:0] rx);
        host_bits(tx, 8, rx);
    endtask

    task automatic cs_low();
        @(negedge clk);
        scs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (6) @(negedge clk);
        scs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 sdo", sdo_o, 0);
        chk("R13 irq_n", irq_n_o, 1);
        chk("R13 strobes", {cfg_rd_o, cfg_wr_o, mac_rd_o, mac_wr_o}, 0);
    endtask

    // R1 R2 R3 R4: status byte in both orders, no match gives no data
    task automatic t_status();
        logic [7:0] r;
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        stat = 4'b1010;
        msb_first = 1'b1;
        cs_low();
        host_byte(8'hF0, r);
        chk("R1 R2 status msb", r, 8'h0A);
        host_byte(8'h02, r);
        chk("R4 no data after no match", r, 8'h00);
        host_byte(8'h55, r);
        cs_high();
        msb_first = 1'b0;
        stat = 4'b0110;
        cs_low();
        host_byte(8'h00, r);
        chk("R1 R3 status lsb", r, 8'h06);
        cs_high();
        chk("R4 no write strobes", wr_cnt - w0, 0);
        chk("R4 no read strobes", rd_cnt - r0, 0);
        msb_first = 1'b1;
    endtask

    // R6 R2 R3: MAC write in both orders, bytes beyond length ignored
    task automatic t_mac_write();
        logic [7:0] r;
        int w0;
        w0 = wr_cnt;
        stat = 4'b0010;
        cs_low();
        host_byte(8'h02, r);
        chk("R1 status", r, 8'h02);
        host_byte(8'h03, r);
        host_byte(8'h11, r);
        host_byte(8'hC5, r);
        host_byte(8'h33, r);
        host_byte(8'h44, r);
        cs_high();
        chk("R6 write count", wr_cnt - w0, 3);
        chk("R6 R2 byte0", wr_log[w0 % 16], 8'h11);
        chk("R6 R2 byte1", wr_log[(w0 + 1) % 16], 8'hC5);
        chk("R6 byte2", wr_log[(w0 + 2) % 16], 8'h33);
        msb_first = 1'b0;
        w0 = wr_cnt;
        cs_low();
        host_byte(8'h02, r);
        host_byte(8'h01, r);
        host_byte(8'h81, r);
        host_byte(8'h06, r);
        cs_high();
        chk("R3 lsb write count", wr_cnt - w0, 1);
        chk("R3 lsb write byte", wr_log[w0 % 16], 8'h81);
        msb_first = 1'b1;
    endtask

    // R7: MAC read of three bytes, then zeros
    task automatic t_mac_read();
        logic [7:0] r;
        int r0;
        r0 = rd_cnt;
        stat = 4'b0001;
        cs_low();
        host_byte(8'h01, r);
        host_byte(8'h03, r);
        host_byte(8'h00, r);
        chk("R7 read byte0", r, 8'h50);
        host_byte(8'h00, r);
        chk("R7 read byte1", r, 8'h51);
        host_byte(8'h00, r);
        chk("R7 read byte2", r, 8'h52);
        host_byte(8'h00, r);
        chk("R7 beyond length", r, 8'h00);
        cs_high();
        chk("R7 pop count", rd_cnt - r0, 3);
    endtask

    // R8: configuration write, length value ignored
    task automatic t_cfg_write();
        logic [7:0] r;
        int c0;
        c0 = cfg_wr_cnt;
        stat = 4'b1000;
        cs_low();
        host_byte(8'h08, r);
        host_byte(8'h05, r);
        host_byte(8'h34, r);
        host_byte(8'h12, r);
        host_byte(8'h99, r);
        cs_high();
        chk("R8 cfg write count", cfg_wr_cnt - c0, 1);
        chk("R8 cfg word", cfg_last, 16'h1234);
    endtask

    // R9: configuration read sampled once, low byte first
    task automatic t_cfg_read();
        logic [7:0] r;
        int c0;
        c0 = cfg_rd_cnt;
        stat = 4'b0100;
        cfg_rdata = 16'hBEEF;
        cs_low();
        host_byte(8'h04, r);
        host_byte(8'h02, r);
        host_byte(8'h00, r);
        chk("R9 low byte", r, 8'hEF);
        cfg_rdata = 16'h0000;
        host_byte(8'h00, r);
        chk("R9 high byte", r, 8'hBE);
        cs_high();
        chk("R9 read strobes", cfg_rd_cnt - c0, 1);
    endtask

    // R5: priority among matched positions
    task automatic t_priority();
        logic [7:0] r;
        int w0, r0, c0, cr0;
        w0 = wr_cnt; r0 = rd_cnt; c0 = cfg_wr_cnt; cr0 = cfg_rd_cnt;
        stat = 4'b1111;
        cs_low();
        host_byte(8'h0F, r);
        host_byte(8'h02, r);
        host_byte(8'h78, r);
        host_byte(8'h56, r);
        cs_high();
        chk("R5 cfg write wins", cfg_wr_cnt - c0, 1);
        chk("R5 cfg word", cfg_last, 16'h5678);
        chk("R5 no other strobes", (wr_cnt - w0) + (rd_cnt - r0) + (cfg_rd_cnt - cr0), 0);
        stat = 4'b0011;
        w0 = wr_cnt; r0 = rd_cnt;
        cs_low();
        host_byte(8'h03, r);
        host_byte(8'h01, r);
        host_byte(8'hA7, r);
        cs_high();
        chk("R5 mac write over read", wr_cnt - w0, 1);
        chk("R5 mac read idle", rd_cnt - r0, 0);
    endtask

    // R10: zero length
    task automatic t_len_zero();
        logic [7:0] r;
        int w0;
        w0 = wr_cnt;
        stat = 4'b0010;
        cs_low();
        host_byte(8'h02, r);
        host_byte(8'h00, r);
        host_byte(8'h99, r);
        cs_high();
        chk("R10 zero length", wr_cnt - w0, 0);
    endtask

    // R11: interrupt follows read-pending bits
    task automatic t_irq();
        stat = 4'b0001;
        repeat (3) @(negedge clk);
        chk("R11 mac pending", irq_n_o, 0);
        stat = 4'b0100;
        repeat (3) @(negedge clk);
        chk("R11 cfg pending", irq_n_o, 0);
        stat = 4'b1010;
        repeat (3) @(negedge clk);
        chk("R11 nothing pending", irq_n_o, 1);
    endtask

    // R12: abort mid-byte, then a clean transaction
    task automatic t_abort();
        logic [7:0] r;
        int w0;
        w0 = wr_cnt;
        stat = 4'b0010;
        cs_low();
        host_byte(8'h02, r);
        host_byte(8'h04, r);
        host_bits(8'hAA, 4, r);
        cs_high();
        chk("R12 idle sdo", sdo_o, 0);
        chk("R12 no write on abort", wr_cnt - w0, 0);
        stat = 4'b0011;
        cs_low();
        host_byte(8'h02, r);
        chk("R12 restart status", r, 8'h03);
        host_byte(8'h01, r);
        host_byte(8'h6D, r);
        cs_high();
        chk("R12 write after restart", wr_cnt - w0, 1);
        chk("R12 written byte", wr_log[w0 % 16], 8'h6D);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_status();
        t_mac_write();
        t_mac_read();
        t_cfg_write();
        t_cfg_read();
        t_priority();
        t_len_zero();
        t_irq();
        t_abort();
        summary();
    end

endmodule